// File: doc/BRIEF.md
# Mixed-Sign Packed Saturating Accumulator

This block adds a packed source vector into a packed accumulator vector, lane by lane, where the two operands in each lane are read with opposite signedness. A direction bit picks which side is signed. Each lane sum is clamped to the numeric range of the accumulator's own interpretation, and the clamped value becomes the new accumulator lane. The caller picks the lane width (8, 16, 32 or 64 bits) from a 2-bit code. It also picks a full 128-bit or half 64-bit vector, or a scalar mode that works on a single lane.

An operation is launched with a one-cycle start strobe. The result register and a valid pulse appear on the next clock edge. A sticky saturation flag records whether any active lane was clamped since it was last cleared, and a synchronous clear input resets it. One combination of lane width and vector width has no meaning. That combination raises an undefined flag and touches neither the result nor the sticky flag.

Top module: `msacc_top`

## Requirements
- R1: The lane width is 8 shifted left by `size_i` (0→8, 1→16, 2→32, 3→64 bits). Lane e occupies bits [e*W+W-1 : e*W] of the source, the accumulator and the result.
- R2: In vector mode, `wide_i`=1 processes 128/W lanes and `wide_i`=0 processes 64/W lanes. When the active width is 64 bits, result bits 127:64 are zero.
- R3: When `scalar_i`=1, only lane 0 is processed, at the selected lane width, and every result bit above it is zero.
- R4: With `scalar_i`=0, `size_i`=3 and `wide_i`=0, the operation is undefined. `undef_o` reads 1 after it, while `result_o` and `sat_o` keep their previous values. `undef_o` reads 0 after any other operation.
- R5: With `dir_i`=1, source lanes are two's-complement signed and accumulator lanes are unsigned. Each sum is clamped to [0, 2^W-1]. For example, an all-ones accumulator plus a positive source gives all ones, and zero plus a negative source gives zero.
- R6: With `dir_i`=0, source lanes are unsigned and accumulator lanes are two's-complement signed. Each sum is clamped to [-2^(W-1), 2^(W-1)-1]. For example, a large unsigned source clamps to the signed maximum.
- R7: `sat_o` becomes 1 after an operation in which any active lane was clamped. Lanes that are inactive never set it. A later operation that does not clamp does not clear it.
- R8: `sat_clr_i` clears `sat_o` on the next edge and takes priority over a saturation in the same cycle.
- R9: `result_o`, `undef_o` and `valid_o` update on the clock edge that samples `start_i`=1. `valid_o` is high for exactly that one cycle.
- R10: After synchronous reset, `result_o`, `valid_o`, `undef_o` and `sat_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch strobe, one cycle |
| src_i | input | 128 | Packed source operand |
| acc_i | input | 128 | Packed accumulator operand |
| size_i | input | 2 | Lane width code |
| wide_i | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| scalar_i | input | 1 | 1 = single-lane scalar operation |
| dir_i | input | 1 | 1 = signed source into unsigned accumulator; 0 = the reverse |
| sat_clr_i | input | 1 | Synchronous clear of the sticky flag |
| result_o | output | 128 | Registered packed result |
| valid_o | output | 1 | One-cycle pulse after a start |
| undef_o | output | 1 | Last operation used the undefined combination |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
A wrong lane-enable pattern or bank selection shows up on the very next valid pulse. It appears as nonzero upper result bits or a misplaced lane, and a spurious or missing `sat_o` follows from lanes that should or should not count. The flag state is more subtle: a sticky bit that is lost or set in error only surfaces when `sat_o` is read after later non-clamping or reserved operations. For that reason the bench reads the flag after sequences of such operations and not only after single ones. Clamp-boundary errors appear only with operands at the exact range edges, so those are driven directly.

// File: rtl/msacc_pkg.sv
package msacc_pkg;

    localparam int unsigned VEC_W   = 128;
    localparam int unsigned HALF_W  = VEC_W / 2;
    localparam int unsigned N_SIZES = 4;
    localparam int unsigned SIZE_W  = $clog2(N_SIZES);

    typedef enum logic [SIZE_W-1:0] {
        LANE_B = 2'd0,
        LANE_H = 2'd1,
        LANE_S = 2'd2,
        LANE_D = 2'd3
    } lane_sz_e;

    typedef struct packed {
        logic [VEC_W-1:0] src;
        logic [VEC_W-1:0] acc;
        lane_sz_e         size;
        logic             wide;
        logic             scalar;
        logic             dir;
    } op_req_t;

    function automatic logic is_reserved(input op_req_t r);
        return !r.scalar && (r.size == LANE_D) && !r.wide;
    endfunction

endpackage

// File: rtl/msacc_lane.sv
module msacc_lane #(
    parameter int unsigned LW = 8
) (
    input  logic [LW-1:0] src_i,
    input  logic [LW-1:0] acc_i,
    input  logic          dir_i,
    input  logic          en_i,
    output logic [LW-1:0] res_o,
    output logic          sat_o
);
    localparam int unsigned SW = LW + 2;
    localparam logic signed [SW-1:0] U_MAX = {2'b00, {LW{1'b1}}};
    localparam logic signed [SW-1:0] S_MAX = {3'b000, {(LW-1){1'b1}}};
    localparam logic signed [SW-1:0] S_MIN = {3'b111, {(LW-1){1'b0}}};

    logic signed [SW-1:0] s_ext, a_ext, sum, hi, lo;
    logic [LW-1:0] clamped;
    logic          over;

    always_comb begin
        s_ext = dir_i ? {{2{src_i[LW-1]}}, src_i} : {2'b00, src_i};
        a_ext = dir_i ? {2'b00, acc_i} : {{2{acc_i[LW-1]}}, acc_i};
        sum   = s_ext + a_ext;
        hi    = dir_i ? U_MAX : S_MAX;
        lo    = dir_i ? '0 : S_MIN;
        if (sum > hi) begin
            clamped = hi[LW-1:0];
            over    = 1'b1;
        end else if (sum < lo) begin
            clamped = lo[LW-1:0];
            over    = 1'b1;
        end else begin
            clamped = sum[LW-1:0];
            over    = 1'b0;
        end
    end

    assign res_o = en_i ? clamped : '0;
    assign sat_o = en_i & over;

endmodule

// File: rtl/msacc_bank.sv
module msacc_bank
    import msacc_pkg::*;
#(
    parameter int unsigned LW = 8
) (
    input  logic [VEC_W-1:0] src_i,
    input  logic [VEC_W-1:0] acc_i,
    input  logic             dir_i,
    input  logic             wide_i,
    input  logic             scalar_i,
    output logic [VEC_W-1:0] res_o,
    output logic             sat_o
);
    localparam int unsigned N_LANES = VEC_W / LW;
    localparam int unsigned N_HALF  = HALF_W / LW;

    logic [N_LANES-1:0] lane_sat;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic en;
        if (i == 0) begin : g_first
            assign en = 1'b1;
        end else if (i < N_HALF) begin : g_low
            assign en = !scalar_i;
        end else begin : g_high
            assign en = !scalar_i && wide_i;
        end

        msacc_lane #(.LW(LW)) u_lane (
            .src_i (src_i[i*LW +: LW]),
            .acc_i (acc_i[i*LW +: LW]),
            .dir_i (dir_i),
            .en_i  (en),
            .res_o (res_o[i*LW +: LW]),
            .sat_o (lane_sat[i])
        );
    end

    assign sat_o = |lane_sat;

endmodule

// File: rtl/msacc_top.sv
module msacc_top
    import msacc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [VEC_W-1:0]    src_i,
    input  logic [VEC_W-1:0]    acc_i,
    input  logic [SIZE_W-1:0]   size_i,
    input  logic                wide_i,
    input  logic                scalar_i,
    input  logic                dir_i,
    input  logic                sat_clr_i,
    output logic [VEC_W-1:0]    result_o,
    output logic                valid_o,
    output logic                undef_o,
    output logic                sat_o
);
    op_req_t            req;
    logic [VEC_W-1:0]   bank_res [N_SIZES];
    logic [N_SIZES-1:0] bank_sat;
    logic [VEC_W-1:0]   sel_res;
    logic               sel_sat;
    logic               reserved;

    assign req = '{src: src_i, acc: acc_i, size: lane_sz_e'(size_i),
                   wide: wide_i, scalar: scalar_i, dir: dir_i};

    for (genvar g = 0; g < N_SIZES; g++) begin : g_bank
        msacc_bank #(.LW(8 << g)) u_bank (
            .src_i    (req.src),
            .acc_i    (req.acc),
            .dir_i    (req.dir),
            .wide_i   (req.wide),
            .scalar_i (req.scalar),
            .res_o    (bank_res[g]),
            .sat_o    (bank_sat[g])
        );
    end

    assign sel_res  = bank_res[req.size];
    assign sel_sat  = bank_sat[req.size];
    assign reserved = is_reserved(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            valid_o  <= 1'b0;
            undef_o  <= 1'b0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                undef_o <= reserved;
                if (!reserved) result_o <= sel_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                   sat_o <= 1'b0;
        else if (sat_clr_i)                        sat_o <= 1'b0;
        else if (start_i && !reserved && sel_sat)  sat_o <= 1'b1;
    end

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);
    p_reserved_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !scalar_i && size_i == 2'd3 && !wide_i)
        |=> ($stable(result_o) && undef_o && (sat_o || !$past(sat_o) || $past(sat_clr_i))));
    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sat_o && !sat_clr_i) |=> sat_o);
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        sat_clr_i |=> !sat_o);
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !wide_i && !(size_i == 2'd3 && !scalar_i)) |=> (result_o[VEC_W-1:HALF_W] == '0));
    p_scalar_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (start_i && scalar_i && size_i == 2'd0) |=> (result_o[VEC_W-1:8] == '0));

endmodule

// File: tb/tb_msacc_top.sv
module tb_msacc_top;
    typedef struct packed {
        logic [127:0] src;
        logic [127:0] acc;
        logic [1:0]   size;
        logic         wide;
        logic         scalar;
        logic         dir;
    } vec_t;

    localparam logic [127:0] PA = 128'h00FF_7F80_0102_0304_FFFE_8001_090A_0B0C;
    localparam logic [127:0] PB = 128'h80FF_0001_FFFE_1000_7FFF_FFFF_4000_5000;
    localparam logic [127:0] PC = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
    localparam logic [127:0] PD = 128'h7FFF_FFFF_FFFF_FFFF_7FFF_FFFF_FFFF_FFFF;
    localparam logic [127:0] PE = 128'h8000_0000_0000_0001_0000_0000_0000_0005;

    localparam int N_TBL = 10;
    localparam vec_t TBL [N_TBL] = '{
        '{PA, PB, 2'd0, 1'b1, 1'b0, 1'b1},
        '{PA, PB, 2'd1, 1'b1, 1'b0, 1'b0},
        '{PA, PB, 2'd2, 1'b0, 1'b0, 1'b1},
        '{PA, PB, 2'd3, 1'b1, 1'b0, 1'b0},
        '{PA, PB, 2'd1, 1'b0, 1'b1, 1'b1},
        '{PA, PB, 2'd2, 1'b1, 1'b1, 1'b0},
        '{PC, PD, 2'd0, 1'b1, 1'b0, 1'b0},
        '{PE, PC, 2'd3, 1'b1, 1'b0, 1'b1},
        '{PC, PE, 2'd2, 1'b0, 1'b0, 1'b0},
        '{PB, PA, 2'd3, 1'b1, 1'b1, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] src = '0, acc = '0;
    logic [1:0]   size = '0;
    logic         wide = 1'b0, scalar = 1'b0, dir = 1'b0, clr = 1'b0;
    logic [127:0] result;
    logic         valid, undef, sat;
    int           n_chk = 0, n_bad = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    msacc_top dut (
        .clk(clk), .rst(rst), .start_i(start), .src_i(src), .acc_i(acc),
        .size_i(size), .wide_i(wide), .scalar_i(scalar), .dir_i(dir),
        .sat_clr_i(clr), .result_o(result), .valid_o(valid),
        .undef_o(undef), .sat_o(sat)
    );

    function automatic void model(input vec_t v, output logic [127:0] r, output logic s);
        int lw = 8 << v.size;
        int n  = v.scalar ? 1 : ((v.wide ? 128 : 64) / lw);
        logic [63:0] m = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        r = '0;
        s = 1'b0;
        for (int e = 0; e < n; e++) begin
            logic [63:0] sv, av;
            logic signed [67:0] sx, ax, sum, hi, lo;
            sv = 64'(v.src >> (e * lw)) & m;
            av = 64'(v.acc >> (e * lw)) & m;
            sx = {4'b0, sv};
            ax = {4'b0, av};
            if (v.dir && sv[lw-1])  sx = sx - (68'sd1 <<< lw);
            if (!v.dir && av[lw-1]) ax = ax - (68'sd1 <<< lw);
            sum = sx + ax;
            hi  = v.dir ? (68'sd1 <<< lw) - 68'sd1 : (68'sd1 <<< (lw - 1)) - 68'sd1;
            lo  = v.dir ? 68'sd0 : -(68'sd1 <<< (lw - 1));
            if (sum > hi) begin
                sum = hi; s = 1'b1;
            end else if (sum < lo) begin
                sum = lo; s = 1'b1;
            end
            r = r | ({64'b0, sum[63:0] & m} << (e * lw));
        end
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input vec_t v, input logic c);
        @(negedge clk);
        src = v.src; acc = v.acc; size = v.size;
        wide = v.wide; scalar = v.scalar; dir = v.dir;
        start = 1'b1; clr = c;
        @(negedge clk);
        start = 1'b0; clr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [127:0] er;
        logic         es;
        logic [127:0] held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 result", result, '0);
        chk("R10 flags", {125'b0, valid, undef, sat}, '0);

        // R1 R2 R3 R5 R6 R7 R9: table walk
        for (int k = 0; k < N_TBL; k++) begin
            clear_flag();
            run(TBL[k], 1'b0);
            model(TBL[k], er, es);
            chk($sformatf("R1/R5/R6 table %0d result", k), result, er);
            chk($sformatf("R7 table %0d sat", k), {127'b0, sat}, {127'b0, es});
            chk($sformatf("R9 table %0d valid", k), {127'b0, valid}, 128'd1);
            @(negedge clk);
            chk($sformatf("R9 table %0d pulse ends", k), {127'b0, valid}, '0);
        end

        // R5: unsigned max plus positive clamps to all ones
        clear_flag();
        run('{128'h01, 128'hFF, 2'd0, 1'b0, 1'b1, 1'b1}, 1'b0);
        chk("R5 max+pos", result, 128'hFF);
        chk("R5 max+pos sat", {127'b0, sat}, 128'd1);
        // R5: zero plus negative clamps to zero
        run('{128'hFF, 128'h00, 2'd0, 1'b0, 1'b1, 1'b1}, 1'b0);
        chk("R5 zero+neg", result, 128'h0);
        // R6: large unsigned source clamps to signed maximum
        run('{128'hFF, 128'h00, 2'd0, 1'b0, 1'b1, 1'b0}, 1'b0);
        chk("R6 big src", result, 128'h7F);
        // R6: most negative accumulator plus zero unchanged
        clear_flag();
        run('{128'h0, 128'h80, 2'd0, 1'b0, 1'b1, 1'b0}, 1'b0);
        chk("R6 min+0", result, 128'h80);
        chk("R6 min+0 no sat", {127'b0, sat}, '0);
        // R2: 64-bit lane, full vector, all-ones accumulator plus one
        run('{{64'd1, 64'd1}, PC, 2'd3, 1'b1, 1'b0, 1'b1}, 1'b0);
        chk("R2 dword lanes", result, PC);

        // R7: saturation only in an inactive upper half must not set the flag
        clear_flag();
        run('{{64'h01010101_01010101, 64'h0}, {64'hFFFFFFFF_FFFFFFFF, 64'h0}, 2'd0, 1'b0, 1'b0, 1'b1}, 1'b0);
        chk("R2 upper zero", result, '0);
        chk("R7 inactive lanes no sat", {127'b0, sat}, '0);
        // R3: scalar ignores upper lanes
        run('{PA, PB, 2'd1, 1'b1, 1'b1, 1'b1}, 1'b0);
        model('{PA, PB, 2'd1, 1'b1, 1'b1, 1'b1}, er, es);
        chk("R3 scalar", result, er);

        // R7: sticky survives a later non-saturating op
        run('{128'h01, 128'hFF, 2'd0, 1'b0, 1'b1, 1'b1}, 1'b0);
        run('{128'h01, 128'h01, 2'd0, 1'b0, 1'b1, 1'b1}, 1'b0);
        chk("R7 sticky", {127'b0, sat}, 128'd1);
        chk("R7 later result", result, 128'h02);

        // R4: reserved combination keeps result and flag, raises undef
        clear_flag();
        held = result;
        run('{PC, PD, 2'd3, 1'b0, 1'b0, 1'b0}, 1'b0);
        chk("R4 undef", {127'b0, undef}, 128'd1);
        chk("R4 result held", result, held);
        chk("R4 sat held", {127'b0, sat}, '0);
        run('{128'h03, 128'h04, 2'd0, 1'b0, 1'b1, 1'b1}, 1'b0);
        chk("R4 undef drops", {127'b0, undef}, '0);
        chk("R4 next result", result, 128'h07);

        // R8: clear wins over a saturation in the same cycle
        run('{128'h01, 128'hFF, 2'd0, 1'b0, 1'b1, 1'b1}, 1'b1);
        chk("R8 clear priority", {127'b0, sat}, '0);
        chk("R8 result still written", result, 128'hFF);

        done = 1'b1;
        finish_run();
    end
endmodule